// File: doc/BRIEF.md
# Dynamic Segment Approximate Multiplier

This block forms an approximate product of two signed 8-bit operands. It does not multiply the full operands. For each operand it takes the magnitude and finds the highest bit that is set. It keeps a 4-bit slice that begins at that bit and runs downward. It then notes how many places that slice sits above bit 0. The two small slices are multiplied together. The product is shifted left by the sum of the two offsets, and the sign of the exact product is applied at the end. The result is a 16-bit two's-complement value that never exceeds the exact product in magnitude.

A caller presents both operands together with a one-cycle strobe. The registered result and its valid flag appear on the next clock edge. Operands small enough to fit in the slice come back exact. Larger operands lose the bits that fall below their slice. A parameter selects the variant: a signed one, which is the default and uses a sign-magnitude treatment, or a plain unsigned one.

Top module: `dsm_approx_mul`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to 0 on that edge.
- R2: `out_valid` is 1 in exactly those cycles that follow a clock edge where `in_valid` was 1.
- R3: `result` keeps its value across any clock edge where `in_valid` is 0, so changes on the operands then have no effect.
- R4: When both operand magnitudes are below 16, `result` equals the exact signed product.
- R5: If either operand is 0, `result` is exactly 0.
- R6: For each operand, let m be its magnitude and s the smallest shift with (m >> s) < 16. Then `result` has the magnitude ((ma >> sa) * (mb >> sb)) << (sa + sb).
- R7: Operands are two's complement, and 8'h80 has magnitude 128. `result` is two's complement and is negated exactly when the operand sign bits differ. The pairs 00 and 11 give a non-negative result.
- R8: The magnitude of `result` never exceeds the magnitude of the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 8 | First operand, two's complement |
| op_b | input | 8 | Second operand, two's complement |
| out_valid | output | 1 | `result` was updated on the last edge |
| result | output | 16 | Approximate product, two's complement |

## Verification
The path is one register deep, so a fault in the leading-one search, the slice extraction or the shift sum shows up on `result` in the cycle right after the strobe. A wrong leading-one index moves the product by a power of two or drops its top bits. Small operands and zero operands give exact values, so any slip there is plain to see. A wrong sign decode flips the sign only on mixed-sign pairs, and the operand table covers all four sign combinations, including the magnitude-128 operand.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int unsigned DSM_OP_W  = 8;
  localparam int unsigned DSM_SEG_W = 4;

  typedef enum logic [1:0] {
    SGN_PP = 2'b00,
    SGN_PN = 2'b01,
    SGN_NP = 2'b10,
    SGN_NN = 2'b11
  } sign_pair_e;
endpackage

// File: rtl/dsm_sign_mag.sv
module dsm_sign_mag #(
  parameter int unsigned OP_W       = 8,
  parameter bit          SIGNED_OPS = 1'b1
) (
  input  logic [OP_W-1:0] value,
  output logic [OP_W-1:0] mag,
  output logic            neg
);
  generate
    if (SIGNED_OPS) begin : g_signed
      always_comb begin
        neg = value[OP_W-1];
        mag = neg ? (~value + 1'b1) : value;
      end
    end else begin : g_unsigned
      always_comb begin
        neg = 1'b0;
        mag = value;
      end
    end
  endgenerate
endmodule

// File: rtl/dsm_segment.sv
module dsm_segment #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned SEG_W = 4,
  localparam int unsigned LD_W = $clog2(OP_W),
  localparam int unsigned SH_W = $clog2(OP_W - SEG_W + 1)
) (
  input  logic [OP_W-1:0]  mag,
  output logic [SEG_W-1:0] seg,
  output logic [SH_W-1:0]  shamt
);
  logic [LD_W-1:0] lead;
  logic [OP_W-1:0] moved;

  // priority search for the highest set bit; the last hit wins
  always_comb begin
    lead = '0;
    for (int i = 0; i < OP_W; i++) begin
      if (mag[i]) lead = LD_W'(i);
    end
  end

  always_comb begin
    if (lead >= LD_W'(SEG_W - 1)) shamt = SH_W'(lead - LD_W'(SEG_W - 1));
    else                          shamt = '0;
    moved = mag >> shamt;
    seg   = moved[SEG_W-1:0];
  end
endmodule

// File: rtl/dsm_seg_product.sv
module dsm_seg_product
  import dsm_pkg::*;
#(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned SEG_W = 4,
  localparam int unsigned SH_W   = $clog2(OP_W - SEG_W + 1),
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic [SEG_W-1:0]  seg_a,
  input  logic [SEG_W-1:0]  seg_b,
  input  logic [SH_W-1:0]   sh_a,
  input  logic [SH_W-1:0]   sh_b,
  input  logic              neg_a,
  input  logic              neg_b,
  output logic [PROD_W-1:0] prod
);
  logic [SH_W:0]       sh_sum;
  logic [PROD_W-1:0]   raw;
  logic [PROD_W-1:0]   scaled;
  sign_pair_e          pair;

  always_comb begin
    sh_sum = {1'b0, sh_a} + {1'b0, sh_b};
    raw    = PROD_W'(seg_a) * PROD_W'(seg_b);
    scaled = raw << sh_sum;
    pair   = sign_pair_e'({neg_a, neg_b});
    case (pair)
      SGN_PP, SGN_NN: prod = scaled;
      SGN_PN, SGN_NP: prod = ~scaled + 1'b1;
      default:        prod = scaled;
    endcase
  end
endmodule

// File: rtl/dsm_approx_mul.sv
module dsm_approx_mul #(
  parameter int unsigned OP_W       = dsm_pkg::DSM_OP_W,
  parameter int unsigned SEG_W      = dsm_pkg::DSM_SEG_W,
  parameter bit          SIGNED_OPS = 1'b1,
  localparam int unsigned SH_W   = $clog2(OP_W - SEG_W + 1),
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] result
);
  logic [OP_W-1:0]   mag_v [2];
  logic              neg_v [2];
  logic [SEG_W-1:0]  seg_v [2];
  logic [SH_W-1:0]   sh_v  [2];
  logic [OP_W-1:0]   op_v  [2];
  logic [PROD_W-1:0] prod_c;

  assign op_v[0] = op_a;
  assign op_v[1] = op_b;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_opnd
      dsm_sign_mag #(.OP_W(OP_W), .SIGNED_OPS(SIGNED_OPS)) sm_i (
        .value(op_v[k]), .mag(mag_v[k]), .neg(neg_v[k])
      );
      dsm_segment #(.OP_W(OP_W), .SEG_W(SEG_W)) seg_i (
        .mag(mag_v[k]), .seg(seg_v[k]), .shamt(sh_v[k])
      );
    end
  endgenerate

  dsm_seg_product #(.OP_W(OP_W), .SEG_W(SEG_W)) prod_i (
    .seg_a(seg_v[0]), .seg_b(seg_v[1]),
    .sh_a(sh_v[0]),   .sh_b(sh_v[1]),
    .neg_a(neg_v[0]), .neg_b(neg_v[1]),
    .prod(prod_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= prod_c;
    end
  end
endmodule

// File: rtl/dsm_approx_mul_chk.sv
module dsm_approx_mul_chk #(
  parameter int unsigned OP_W       = 8,
  parameter bit          SIGNED_OPS = 1'b1,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              out_valid,
  input logic [PROD_W-1:0] result
);
  logic [OP_W-1:0]   ma, mb;
  logic              flip;
  logic [PROD_W-1:0] exact_mag, exact_val, res_mag;
  logic              small_ops;

  always_comb begin
    ma        = (SIGNED_OPS && op_a[OP_W-1]) ? (~op_a + 1'b1) : op_a;
    mb        = (SIGNED_OPS && op_b[OP_W-1]) ? (~op_b + 1'b1) : op_b;
    flip      = SIGNED_OPS && (op_a[OP_W-1] ^ op_b[OP_W-1]);
    exact_mag = PROD_W'(ma) * PROD_W'(mb);
    exact_val = flip ? (~exact_mag + 1'b1) : exact_mag;
    res_mag   = (SIGNED_OPS && result[PROD_W-1]) ? (~result + 1'b1) : result;
    small_ops = (ma < OP_W'(16)) && (mb < OP_W'(16));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result));
  // R4
  exact_small_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && small_ops) |=> result == $past(exact_val));
  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_a == '0 || op_b == '0)) |=> result == '0);
  // R7
  sign_same_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flip) |=> !result[PROD_W-1]);
  // R8
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_mag <= $past(exact_mag));
endmodule

bind dsm_approx_mul dsm_approx_mul_chk #(.OP_W(OP_W), .SIGNED_OPS(SIGNED_OPS)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .result(result)
);

// File: tb/dsm_approx_mul_tb.sv
module dsm_approx_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        out_valid;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dsm_approx_mul dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result)
  );

  // {op_a, op_b, expected result}
  localparam logic [31:0] VEC [13] = '{
    {8'h03, 8'h05, 16'h000F},
    {8'hFD, 8'h05, 16'hFFF1},
    {8'h07, 8'hF9, 16'hFFCF},
    {8'hF8, 8'hF8, 16'h0040},
    {8'h00, 8'h64, 16'h0000},
    {8'h64, 8'h03, 16'h0120},
    {8'h7F, 8'h7F, 16'h3840},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC400},
    {8'h2D, 8'hEC, 16'hFC90},
    {8'h0F, 8'h0F, 16'h00E1},
    {8'h10, 8'h10, 16'h0100},
    {8'h11, 8'h01, 16'h0010}
  };

  function automatic logic [15:0] ref_model(input logic [7:0] a, input logic [7:0] b);
    int sa_v, sb_v, ma, mb, sa, sb, mag;
    sa_v = $signed(a);
    sb_v = $signed(b);
    ma = (sa_v < 0) ? -sa_v : sa_v;
    mb = (sb_v < 0) ? -sb_v : sb_v;
    sa = 0;
    while ((ma >> sa) > 15) sa++;
    sb = 0;
    while ((mb >> sb) > 15) sb++;
    mag = ((ma >> sa) * (mb >> sb)) << (sa + sb);
    if ((sa_v < 0) != (sb_v < 0)) mag = -mag;
    return 16'(mag);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic launch(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(out_valid), 0);
    check("R1 result", 32'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle valid", 32'(out_valid), 0);

    foreach (VEC[i]) begin
      logic [7:0] a, b;
      string tag;
      a = VEC[i][31:24];
      b = VEC[i][23:16];
      tag = (a == 0 || b == 0) ? "R5 zero" :
            (i < 4 || i == 10) ? "R4 exact" :
            (i == 7 || i == 8) ? "R7 sign" : "R6 segment";
      launch(a, b);
      check("R2 valid", 32'(out_valid), 1);
      check(tag, 32'(result), 32'(VEC[i][15:0]));
    end

    // R3: operands change with no strobe
    launch(8'h55, 8'h33);
    op_a = 8'h7F; op_b = 8'h81;
    @(negedge clk);
    check("R3 hold", 32'(result), 32'(ref_model(8'h55, 8'h33)));
    check("R2 no strobe", 32'(out_valid), 0);

    // R2 back-to-back strobes
    @(negedge clk);
    op_a = 8'h21; op_b = 8'h9C; in_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", 32'(result), 32'(ref_model(8'h21, 8'h9C)));
    op_a = 8'hC3; op_b = 8'h47;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", 32'(result), 32'(ref_model(8'hC3, 8'h47)));
    check("R2 b2b valid", 32'(out_valid), 1);

    // R6 / R7 / R8 sweep against the segmentation model
    for (int i = 0; i < 256; i += 11) begin
      for (int j = 0; j < 256; j += 13) begin
        int ea, eb, ex, rm;
        launch(8'(i), 8'(j));
        check("R6 sweep", 32'(result), 32'(ref_model(8'(i), 8'(j))));
        ea = $signed(8'(i)); eb = $signed(8'(j));
        ex = ea * eb; if (ex < 0) ex = -ex;
        rm = $signed(result); if (rm < 0) rm = -rm;
        check("R8 bound", 32'(rm <= ex), 1);
      end
    end

    // R1 reset mid-operation
    launch(8'h7F, 8'h7F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reclear result", 32'(result), 0);
    check("R1 reclear valid", 32'(out_valid), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule